// File: doc/BRIEF.md
# Character Raster Timing Generator

This block produces the scan timing for a display built from character cells. A character clock enable advances a horizontal character counter. At the end of each line a vertical section steps through the raster lines of a character row, then through the character rows of a frame, and then through a short run of extra adjust lines. From these counters the block derives horizontal and vertical sync, a display-enable window, a cursor strobe, a 14-bit memory address for the character store and a 5-bit raster address for the glyph store.

All geometry arrives as static configuration inputs, and software is expected to change them only while reset is held. The horizontal total, the vertical total in rows and the last raster of a row are each programmed as the count minus one. A mode input selects progressive scan, interlaced sync, or interlace with raster interleave. Further inputs select flat or row/column memory addressing, and independent skew delays for display enable and for the cursor. All state advances only on cycles where the character clock enable is high.

Top module: `crt_timing`

## Requirements
- R1: The character counter runs 0..htotal and wraps, so a line lasts htotal+1 enabled cycles. hsync is high for the characters hsync_pos, hsync_pos+1, … for a count given by sync_widths[3:0], where code 0 means 16.
- R2: In progressive mode, raster_addr counts 0..max_ras within each of vtotal+1 character rows. The frame is followed by vadjust extra lines, and during those lines raster_addr counts 0,1,… from zero. The next frame then starts at row 0.
- R3: vsync goes high on the first line of character row vsync_pos and stays high for a count of lines given by sync_widths[7:4], where code 0 means 16.
- R4: The raw display window is active when the character count is below hdisp, the row is below vdisp and the line is not an adjust line.
- R5: With rowcol_mode=0, mem_addr = start_addr + row·hdisp + character count, modulo 2^14. The row base reloads from start_addr at the top of each frame.
- R6: With rowcol_mode=1, mem_addr[7:0] is the character count and mem_addr[13:8] is the character row number (low 6 bits).
- R7: The raw cursor is active inside the display window when mem_addr equals cursor_addr and raster_addr lies within cursor_first..cursor_last inclusive.
- R8: disp_en is the raw display window delayed by de_skew enabled cycles (codes 0, 1, 2). Code 3 acts as no delay.
- R9: cursor is the raw cursor delayed by cur_skew enabled cycles, using the same code meaning as R8.
- R10: With ilace_mode[0]=1 the field flag toggles each frame. In odd fields vsync is shifted later by (htotal+1)/2 character times.
- R11: With ilace_mode=2'b11, raster_addr steps by 2 within a row and starts at the field parity. Even fields show even rasters, odd fields show odd rasters, and each row lasts (max_ras+1)/2 lines.
- R12: With ilace_mode[0]=0 (codes 2'b00 and 2'b10), the scan is progressive and vsync is never shifted.
- R13: While rst is high: mem_addr = start_addr, raster_addr = 0 and vsync = 0.
- R14: In a cycle with cclk_en low, no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cclk_en | input | 1 | Character clock enable |
| htotal | input | 8 | Characters per line minus one |
| hdisp | input | 8 | Displayed characters per line |
| hsync_pos | input | 8 | Character where hsync starts |
| sync_widths | input | 8 | [3:0] hsync width, [7:4] vsync width; 0 means 16 |
| vtotal | input | 7 | Character rows per frame minus one |
| vadjust | input | 5 | Extra lines after the last row |
| vdisp | input | 7 | Displayed character rows |
| vsync_pos | input | 7 | Row where vsync starts |
| max_ras | input | 5 | Last raster of a character row |
| ilace_mode | input | 2 | x0 progressive, 01 interlaced sync, 11 interlace with raster interleave |
| rowcol_mode | input | 1 | 1 selects row/column addressing |
| de_skew | input | 2 | Display enable delay code |
| cur_skew | input | 2 | Cursor delay code |
| start_addr | input | 14 | Frame start address |
| cursor_addr | input | 14 | Cursor cell address |
| cursor_first | input | 5 | First cursor raster |
| cursor_last | input | 5 | Last cursor raster |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| disp_en | output | 1 | Skewed display enable |
| cursor | output | 1 | Skewed cursor strobe |
| mem_addr | output | 14 | Character memory address |
| raster_addr | output | 5 | Raster within the character row |

## Verification
Four configurations are swept for several full frames, and every output is compared on every cycle against a value derived from the elapsed enabled cycle count. The first configuration starts near the top of the address space, so that the flat address visibly wraps; it also uses non-zero sync widths and a non-zero adjust. The second configuration uses sync-width code 0, row/column addressing, the non-interlace code 2'b10 and a gapped clock enable, which separates counting every cycle from counting only enabled ones. The third and fourth configurations alternate fields. The half-line vsync shift tells field parity apart, the interleave mode checks the even/odd raster split, and skew code 3 is run against codes 1 and 2.

// File: rtl/crt_pkg.sv
package crt_pkg;
    localparam int H_W   = 8;
    localparam int V_W   = 7;
    localparam int R_W   = 5;
    localparam int MA_W  = 14;
    localparam int SW_W  = 4;
    localparam int SKEW_DEPTH = 2;

    typedef enum logic [1:0] {
        ILM_PROG     = 2'b00,
        ILM_SYNC     = 2'b01,
        ILM_PROG_ALT = 2'b10,
        ILM_VIDEO    = 2'b11
    } ilace_e;

    typedef struct packed {
        logic [V_W-1:0] row;
        logic [R_W-1:0] ras;
        logic           adj;
        logic           field;
    } vstate_t;

    function automatic logic [SW_W:0] sync_len(input logic [SW_W-1:0] code);
        return (code == '0) ? (SW_W+1)'(1 << SW_W) : {1'b0, code};
    endfunction

    function automatic logic [1:0] skew_taps(input logic [1:0] code);
        return (code == 2'd3) ? 2'd0 : code;
    endfunction
endpackage

// File: rtl/crt_hcount.sv
module crt_hcount
    import crt_pkg::*;
#(
    parameter int HW = H_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ce,
    input  logic [HW-1:0]   htotal,
    input  logic [HW-1:0]   hdisp,
    input  logic [HW-1:0]   hsync_pos,
    input  logic [SW_W-1:0] hsync_code,
    output logic [HW-1:0]   hcnt,
    output logic            line_end,
    output logic            half_tick,
    output logic            h_act,
    output logic            hsync
);
    logic [HW-1:0]  rel;
    logic [HW:0]    hsum;
    logic [HW-1:0]  hhalf;
    logic [SW_W:0]  hlen;

    assign hlen      = sync_len(hsync_code);
    assign rel       = hcnt - hsync_pos;
    assign hsync     = ({1'b0, rel} < (HW+1)'(hlen));
    assign hsum      = {1'b0, htotal} + (HW+1)'(1);
    assign hhalf     = hsum[HW:1];
    assign line_end  = ce && (hcnt == htotal);
    assign half_tick = ce && (hcnt == hhalf - HW'(1));
    assign h_act     = (hcnt < hdisp);

    always_ff @(posedge clk) begin
        if (rst) begin
            hcnt <= '0;
        end else if (ce) begin
            hcnt <= (hcnt == htotal) ? '0 : hcnt + HW'(1);
        end
    end
endmodule

// File: rtl/crt_vcount.sv
module crt_vcount
    import crt_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            line_end,
    input  logic            half_tick,
    input  logic [V_W-1:0]  vtotal,
    input  logic [V_W-1:0]  vsync_pos,
    input  logic [R_W-1:0]  vadjust,
    input  logic [R_W-1:0]  max_ras,
    input  logic [SW_W-1:0] vsync_code,
    input  logic [1:0]      ilace_mode,
    output vstate_t         st,
    output logic            row_end,
    output logic            frame_end,
    output logic [SW_W:0]   vs_left,
    output logic            vsync
);
    ilace_e        mode_e;
    logic          video;
    logic          ilace;
    logic [R_W:0]  step;
    logic [R_W:0]  ras_sum;
    logic          last_ras;
    logic          adj_done;
    logic          vs_trig;
    logic          vs_half;
    vstate_t       nx;

    assign mode_e   = ilace_e'(ilace_mode);
    assign video    = (mode_e == ILM_VIDEO);
    assign ilace    = ilace_mode[0];
    assign step     = video ? (R_W+1)'(2) : (R_W+1)'(1);
    assign ras_sum  = {1'b0, st.ras} + step;
    assign last_ras = (ras_sum > {1'b0, max_ras});
    assign adj_done = (({1'b0, st.ras} + (R_W+1)'(1)) >= {1'b0, vadjust});

    always_comb begin
        nx        = st;
        row_end   = 1'b0;
        frame_end = 1'b0;
        if (line_end) begin
            if (st.adj) begin
                if (adj_done) frame_end = 1'b1;
                else          nx.ras = st.ras + R_W'(1);
            end else if (last_ras) begin
                row_end = 1'b1;
                if (st.row == vtotal) begin
                    if (vadjust == '0) begin
                        frame_end = 1'b1;
                    end else begin
                        nx.adj = 1'b1;
                        nx.ras = '0;
                    end
                end else begin
                    nx.row = st.row + V_W'(1);
                    nx.ras = video ? R_W'(st.field) : '0;
                end
            end else begin
                nx.ras = ras_sum[R_W-1:0];
            end
            if (frame_end) begin
                nx.row   = '0;
                nx.adj   = 1'b0;
                nx.field = ilace ? ~st.field : 1'b0;
                nx.ras   = video ? R_W'(nx.field) : '0;
            end
        end
    end

    assign vs_trig = (row_end || frame_end) && !nx.adj && (nx.row == vsync_pos);

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= '0;
            vs_left <= '0;
            vs_half <= 1'b0;
        end else begin
            st <= nx;
            if (vs_trig) begin
                vs_left <= sync_len(vsync_code);
            end else if (line_end && vs_left != '0) begin
                vs_left <= vs_left - (SW_W+1)'(1);
            end
            if (half_tick) vs_half <= (vs_left != '0);
        end
    end

    assign vsync = (ilace && st.field) ? vs_half : (vs_left != '0);
endmodule

// File: rtl/crt_skew.sv
module crt_skew #(
    parameter int DEPTH = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ce,
    input  logic [1:0] sel,
    input  logic       din,
    output logic       dout
);
    logic [DEPTH:0] taps;

    assign taps[0] = din;

    for (genvar i = 1; i <= DEPTH; i++) begin : g_tap
        always_ff @(posedge clk) begin
            if (rst)     taps[i] <= 1'b0;
            else if (ce) taps[i] <= taps[i-1];
        end
    end

    assign dout = taps[sel];
endmodule

// File: rtl/crt_timing.sv
module crt_timing
    import crt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cclk_en,
    input  logic [7:0]  htotal,
    input  logic [7:0]  hdisp,
    input  logic [7:0]  hsync_pos,
    input  logic [7:0]  sync_widths,
    input  logic [6:0]  vtotal,
    input  logic [4:0]  vadjust,
    input  logic [6:0]  vdisp,
    input  logic [6:0]  vsync_pos,
    input  logic [4:0]  max_ras,
    input  logic [1:0]  ilace_mode,
    input  logic        rowcol_mode,
    input  logic [1:0]  de_skew,
    input  logic [1:0]  cur_skew,
    input  logic [13:0] start_addr,
    input  logic [13:0] cursor_addr,
    input  logic [4:0]  cursor_first,
    input  logic [4:0]  cursor_last,
    output logic        hsync,
    output logic        vsync,
    output logic        disp_en,
    output logic        cursor,
    output logic [13:0] mem_addr,
    output logic [4:0]  raster_addr
);
    localparam int ROW_BITS = MA_W - H_W;

    logic [H_W-1:0]  hcnt;
    logic            line_end;
    logic            half_tick;
    logic            h_act;
    vstate_t         vst;
    logic            row_end;
    logic            frame_end;
    logic [SW_W:0]   vs_left;
    logic [MA_W-1:0] ma_row;
    logic            de_raw;
    logic            cur_raw;
    logic            in_adj;
    logic            field;

    crt_hcount u_h (
        .clk        (clk),
        .rst        (rst),
        .ce         (cclk_en),
        .htotal     (htotal),
        .hdisp      (hdisp),
        .hsync_pos  (hsync_pos),
        .hsync_code (sync_widths[SW_W-1:0]),
        .hcnt       (hcnt),
        .line_end   (line_end),
        .half_tick  (half_tick),
        .h_act      (h_act),
        .hsync      (hsync)
    );

    crt_vcount u_v (
        .clk        (clk),
        .rst        (rst),
        .line_end   (line_end),
        .half_tick  (half_tick),
        .vtotal     (vtotal),
        .vsync_pos  (vsync_pos),
        .vadjust    (vadjust),
        .max_ras    (max_ras),
        .vsync_code (sync_widths[2*SW_W-1:SW_W]),
        .ilace_mode (ilace_mode),
        .st         (vst),
        .row_end    (row_end),
        .frame_end  (frame_end),
        .vs_left    (vs_left),
        .vsync      (vsync)
    );

    assign in_adj      = vst.adj;
    assign field       = vst.field;
    assign raster_addr = vst.ras;

    always_ff @(posedge clk) begin
        if (rst || frame_end) ma_row <= start_addr;
        else if (row_end)     ma_row <= ma_row + MA_W'(hdisp);
    end

    assign mem_addr = rowcol_mode ? {vst.row[ROW_BITS-1:0], hcnt}
                                  : ma_row + MA_W'(hcnt);

    assign de_raw  = h_act && (vst.row < vdisp) && !vst.adj;
    assign cur_raw = de_raw && (mem_addr == cursor_addr)
                     && (raster_addr >= cursor_first) && (raster_addr <= cursor_last);

    crt_skew #(.DEPTH(SKEW_DEPTH)) u_de_skew (
        .clk  (clk),
        .rst  (rst),
        .ce   (cclk_en),
        .sel  (skew_taps(de_skew)),
        .din  (de_raw),
        .dout (disp_en)
    );

    crt_skew #(.DEPTH(SKEW_DEPTH)) u_cur_skew (
        .clk  (clk),
        .rst  (rst),
        .ce   (cclk_en),
        .sel  (skew_taps(cur_skew)),
        .din  (cur_raw),
        .dout (cursor)
    );
endmodule

// File: rtl/crt_timing_chk.sv
module crt_timing_chk (
    input logic        clk,
    input logic        rst,
    input logic        cclk_en,
    input logic [1:0]  de_skew,
    input logic [1:0]  cur_skew,
    input logic [1:0]  ilace_mode,
    input logic        rowcol_mode,
    input logic [13:0] start_addr,
    input logic [7:0]  htotal,
    input logic [7:0]  hcnt,
    input logic [13:0] mem_addr,
    input logic [4:0]  raster_addr,
    input logic        disp_en,
    input logic        cursor,
    input logic        de_raw,
    input logic        cur_raw,
    input logic        frame_end,
    input logic [4:0]  vs_left,
    input logic        in_adj,
    input logic        field
);
    p_hcnt_bound_r1: assert property (@(posedge clk) disable iff (rst)
        hcnt <= htotal);

    p_vs_len_r3: assert property (@(posedge clk) disable iff (rst)
        vs_left <= 5'd16);

    p_frame_reload_r5: assert property (@(posedge clk) disable iff (rst)
        (frame_end && !rowcol_mode) |=> (mem_addr == $past(start_addr)));

    p_de_skew_r8: assert property (@(posedge clk) disable iff (rst)
        (cclk_en && de_skew == 2'd1) |=> (disp_en == $past(de_raw)));

    p_cur_skew_r9: assert property (@(posedge clk) disable iff (rst)
        (cclk_en && cur_skew == 2'd1) |=> (cursor == $past(cur_raw)));

    p_video_parity_r11: assert property (@(posedge clk) disable iff (rst)
        (ilace_mode == 2'b11 && !in_adj) |-> (raster_addr[0] == field));

    p_field_zero_r12: assert property (@(posedge clk) disable iff (rst)
        !ilace_mode[0] |-> !field);

    p_stall_r14: assert property (@(posedge clk) disable iff (rst)
        !cclk_en |=> ($stable(mem_addr) && $stable(raster_addr) && $stable(disp_en)));
endmodule

bind crt_timing crt_timing_chk u_chk (.*);

// File: tb/sim_crt_timing.sv
module sim_crt_timing;
    logic        clk = 1'b0;
    logic        rst, cclk_en;
    logic [7:0]  htotal, hdisp, hsync_pos, sync_widths;
    logic [6:0]  vtotal, vdisp, vsync_pos;
    logic [4:0]  vadjust, max_ras, cursor_first, cursor_last;
    logic [1:0]  ilace_mode, de_skew, cur_skew;
    logic        rowcol_mode;
    logic [13:0] start_addr, cursor_addr;
    logic        hsync, vsync, disp_en, cursor;
    logic [13:0] mem_addr;
    logic [4:0]  raster_addr;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    crt_timing u0 (.*);

    typedef struct {
        int h; int row; int ras; int ma;
        bit adj; bit de; bit cur; bit hs; bit vs;
    } exp_t;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int lines_per_row();
        return (ilace_mode == 2'b11) ? (int'(max_ras) + 1) / 2 : int'(max_ras) + 1;
    endfunction

    function automatic bit vs_line(input int ln);
        int lpr, fl, lf, p, vw;
        lpr = lines_per_row();
        fl  = (int'(vtotal) + 1) * lpr + int'(vadjust);
        lf  = ln % fl;
        p   = int'(vsync_pos) * lpr;
        vw  = (sync_widths[7:4] == 4'd0) ? 16 : int'(sync_widths[7:4]);
        return (lf >= p) && (lf < p + vw);
    endfunction

    function automatic exp_t model(input int te);
        exp_t e;
        int ht, lpr, rows, fl, ln, lf, fld, k, hw, base;
        bit vid, il;
        ht   = int'(htotal) + 1;
        vid  = (ilace_mode == 2'b11);
        il   = ilace_mode[0];
        lpr  = lines_per_row();
        rows = int'(vtotal) + 1;
        fl   = rows * lpr + int'(vadjust);
        ln   = te / ht;
        e.h  = te % ht;
        lf   = ln % fl;
        fld  = il ? (ln / fl) % 2 : 0;
        e.adj = (lf >= rows * lpr);
        if (e.adj) begin
            e.row = int'(vtotal);
            e.ras = lf - rows * lpr;
            base  = int'(start_addr) + rows * int'(hdisp);
        end else begin
            e.row = lf / lpr;
            k     = lf % lpr;
            e.ras = vid ? fld + 2 * k : k;
            base  = int'(start_addr) + e.row * int'(hdisp);
        end
        e.ma  = rowcol_mode ? ((e.row % 64) * 256 + e.h) : (base + e.h) % 16384;
        e.de  = !e.adj && (e.h < int'(hdisp)) && (e.row < int'(vdisp));
        e.cur = e.de && (e.ma == int'(cursor_addr)) &&
                (e.ras >= int'(cursor_first)) && (e.ras <= int'(cursor_last));
        hw    = (sync_widths[3:0] == 4'd0) ? 16 : int'(sync_widths[3:0]);
        e.hs  = ((e.h - int'(hsync_pos)) & 255) < hw;
        if (il && fld == 1)
            e.vs = (e.h >= ht / 2) ? vs_line(ln) : ((ln == 0) ? 1'b0 : vs_line(ln - 1));
        else
            e.vs = vs_line(ln);
        return e;
    endfunction

    function automatic int taps(input logic [1:0] code);
        return (code == 2'd3) ? 0 : int'(code);
    endfunction

    task automatic run(input string vtag, input string rtag, input string mtag,
                       input string dtag, input string ctag, input int ncyc, input bit stall);
        int te;
        int prev_ma;
        bit prev_ce;
        exp_t e;
        exp_t ed;
        exp_t ec;
        rst = 1'b1;
        cclk_en = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R13", "reset mem_addr", int'(mem_addr), int'(start_addr));
        chk("R13", "reset raster_addr", int'(raster_addr), 0);
        chk("R13", "reset vsync", int'(vsync), 0);
        rst = 1'b0;
        te = 0;
        prev_ce = 1'b1;
        prev_ma = int'(mem_addr);
        for (int c = 0; c < ncyc; c++) begin
            bit ce_now;
            e = model(te);
            chk("R1", "hsync", int'(hsync), int'(e.hs));
            chk(vtag, "vsync", int'(vsync), int'(e.vs));
            chk(rtag, "raster_addr", int'(raster_addr), e.ras);
            if (!e.adj) chk(mtag, "mem_addr", int'(mem_addr), e.ma);
            if (te >= taps(de_skew)) begin
                ed = model(te - taps(de_skew));
                chk(dtag, "disp_en", int'(disp_en), int'(ed.de));
            end else begin
                chk(dtag, "disp_en", int'(disp_en), 0);
            end
            if (te >= taps(cur_skew)) begin
                ec = model(te - taps(cur_skew));
                chk(ctag, "cursor", int'(cursor), int'(ec.cur));
            end else begin
                chk(ctag, "cursor", int'(cursor), 0);
            end
            if (!prev_ce) chk("R14", "stalled mem_addr", int'(mem_addr), prev_ma);
            prev_ma = int'(mem_addr);
            ce_now  = stall ? ((c % 7) != 3 && (c % 11) != 5) : 1'b1;
            cclk_en = ce_now;
            @(negedge clk);
            if (ce_now) te++;
            prev_ce = ce_now;
        end
    endtask

    initial begin
        rst = 1'b1;
        cclk_en = 1'b1;

        // A: flat addressing with 14-bit wrap, nonzero sync widths, adjust lines
        htotal = 8'd19; hdisp = 8'd12; hsync_pos = 8'd14; sync_widths = 8'h34;
        vtotal = 7'd5; vadjust = 5'd2; vdisp = 7'd4; vsync_pos = 7'd4; max_ras = 5'd3;
        ilace_mode = 2'b00; rowcol_mode = 1'b0; de_skew = 2'd0; cur_skew = 2'd0;
        start_addr = 14'h3FF0; cursor_addr = 14'h000D; cursor_first = 5'd1; cursor_last = 5'd2;
        run("R3", "R2", "R5", "R4", "R7", 1700, 1'b0);

        // B: width code 0 (16), row/column addressing, mode 2'b10, gapped enable
        htotal = 8'd39; hdisp = 8'd30; hsync_pos = 8'd20; sync_widths = 8'h00;
        vtotal = 7'd7; vadjust = 5'd0; vdisp = 7'd6; vsync_pos = 7'd2; max_ras = 5'd3;
        ilace_mode = 2'b10; rowcol_mode = 1'b1; de_skew = 2'd1; cur_skew = 2'd2;
        start_addr = 14'h0000; cursor_addr = 14'h0207; cursor_first = 5'd0; cursor_last = 5'd3;
        run("R3 R12", "R2", "R6", "R8", "R9", 4000, 1'b1);

        // C: interlaced sync, half-line shift on odd fields
        htotal = 8'd20; hdisp = 8'd10; hsync_pos = 8'd12; sync_widths = 8'h23;
        vtotal = 7'd3; vadjust = 5'd1; vdisp = 7'd3; vsync_pos = 7'd1; max_ras = 5'd2;
        ilace_mode = 2'b01; rowcol_mode = 1'b0; de_skew = 2'd2; cur_skew = 2'd1;
        start_addr = 14'h0000; cursor_addr = 14'd24; cursor_first = 5'd0; cursor_last = 5'd2;
        run("R10", "R2", "R5", "R8", "R9", 1200, 1'b0);

        // D: raster interleave, skew code 3
        htotal = 8'd15; hdisp = 8'd8; hsync_pos = 8'd10; sync_widths = 8'h12;
        vtotal = 7'd4; vadjust = 5'd3; vdisp = 7'd4; vsync_pos = 7'd3; max_ras = 5'd5;
        ilace_mode = 2'b11; rowcol_mode = 1'b0; de_skew = 2'd3; cur_skew = 2'd3;
        start_addr = 14'h0100; cursor_addr = 14'h010A; cursor_first = 5'd2; cursor_last = 5'd3;
        run("R10", "R11", "R5", "R8", "R9", 1300, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule